// File: doc/BRIEF.md
# Dense-to-Sparse Spike Event Streamer

This block turns a dense binary spike map into a stream of spike events. The map is delivered one word at a time over a valid/ready input. Each word covers one rectangular tile of the map, and tiles arrive in raster order. For every set bit the block emits the (x, y) pixel coordinate of that spike over a valid/ready output. The convolution units downstream consume only real events and never scan empty pixels.

Two lowest-set-bit search trees look at the word being worked on. The first tree finds the spike to emit in the current cycle. The second tree looks at what is left once that bit is removed, so the block knows in advance whether the current spike is the last one in the word. This lets the final spike of a word and the acceptance of the next word happen in the same cycle. A compile-time lookup table converts the bit position into a pixel offset inside the tile. Words with no set bits are consumed in one cycle and produce nothing. The one exception is the last word of a map: if it is empty, it produces a marker beat that closes the map.

Top module: `spikeStreamer`

## Requirements
- R1: After reset, outValid is 0, inReady is 1, and the tile position is the top-left tile (0, 0).
- R2: Bit b of a word covers the pixel (tileX + b mod TILE_W, tileY + b div TILE_W), where (tileX, tileY) is the top-left pixel of that word's tile. Tiles advance left to right by TILE_W, then top to bottom by TILE_H, starting at (0, 0).
- R3: The spikes of a word are emitted in ascending bit order, one beat per cycle while outReady is high, with outSpike = 1 on each beat.
- R4: In the cycle the last remaining spike of the held word is accepted, inReady is 1, so the next word can be taken with no idle cycle between them.
- R5: A word with no set bits is accepted in a single cycle, produces no beat, and still advances the tile position.
- R6: While outValid is 1 and outReady is 0, the output beat (outSpike, outEom, outX, outY) stays unchanged in the next cycle, and inReady is 0.
- R7: The final spike of the last word of a map carries outEom = 1. Every other spike carries outEom = 0.
- R8: If the last word of a map has no set bits, the block emits one marker beat with outSpike = 0 and outEom = 1 after all earlier spikes.
- R9: After the last tile of a map, the tile position returns to (0, 0) for the next map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Spike word offered |
| inReady | output | 1 | Spike word accepted this cycle when inValid is also 1 |
| inWord | input | TILE_W*TILE_H | One tile of the spike map; bit b is pixel (b mod TILE_W, b div TILE_W) of the tile |
| outValid | output | 1 | Event beat present |
| outReady | input | 1 | Downstream takes the beat |
| outSpike | output | 1 | 1 for a spike beat, 0 for an end-of-map marker |
| outEom | output | 1 | Beat closes the map |
| outX | output | $clog2(MAP_W) | Spike column |
| outY | output | $clog2(MAP_H) | Spike row |

## Verification
The bench drives streams of dense, sparse, all-empty, single-bit and all-ones tiles. A behavioural queue model predicts every cycle's handshake and beat. A design that leaves a gap after the last spike of a word shows inReady low where the model expects it high. A design that drops or repeats a bit when the two trees disagree emits the wrong coordinates or the wrong number of beats. Random downstream stalls check that a held beat does not change and that no word is taken during a stall. Maps that end on an empty tile check that the marker appears exactly once, after the last spike. Coordinates are checked to restart at (0, 0) on the next map.

// File: rtl/spkPkg.sv
package spkPkg;

  typedef struct packed {
    logic load;      // capture the offered word as the working word
    logic clearBit;  // drop the emitted bit from the working word
    logic advance;   // move the tile position on by one word
  } spkStrobeT;

  typedef struct packed {
    logic inZero;     // offered word carries no spikes
    logic inTileLast; // offered word is the last tile of the map
    logic oneLeft;    // working word has exactly one set bit
    logic workLast;   // working word is the last tile of the map
    logic hasBit;     // working word has at least one set bit
  } spkStatusT;

endpackage

// File: rtl/spkLzc.sv
// Lowest-set-bit search built as a binary tree. The lower half wins at
// every node, so the result is the smallest set index.
module spkLzc #(
  parameter int W = 16
) (
  input  logic [W-1:0]         vec,
  output logic                 found,
  output logic [$clog2(W)-1:0] idx
);
  localparam int L = $clog2(W);
  localparam int P = 1 << L;
  localparam int N = 2 * P - 1;

  logic [N-1:0]        nodeVal;
  logic [N-1:0][L-1:0] nodeIdx;

  genvar i;
  generate
    for (i = 0; i < P; i++) begin : gLeaf
      if (i < W) begin : gReal
        assign nodeVal[P-1+i] = vec[i];
      end else begin : gPad
        assign nodeVal[P-1+i] = 1'b0;
      end
      assign nodeIdx[P-1+i] = L'(i);
    end
    for (i = 0; i < P - 1; i++) begin : gNode
      assign nodeVal[i] = nodeVal[2*i+1] | nodeVal[2*i+2];
      assign nodeIdx[i] = nodeVal[2*i+1] ? nodeIdx[2*i+1] : nodeIdx[2*i+2];
    end
  endgenerate

  assign found = nodeVal[0];
  assign idx   = nodeIdx[0];
endmodule

// File: rtl/spkDatapath.sv
module spkDatapath
  import spkPkg::*;
#(
  parameter int TILE_W = 4,
  parameter int TILE_H = 4,
  parameter int MAP_W  = 32,
  parameter int MAP_H  = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  spkStrobeT                      strobe,
  input  logic [TILE_W*TILE_H-1:0]       inWord,
  output spkStatusT                      status,
  output logic [$clog2(MAP_W)-1:0]       outX,
  output logic [$clog2(MAP_H)-1:0]       outY
);
  localparam int WORD_W = TILE_W * TILE_H;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int X_W    = $clog2(MAP_W);
  localparam int Y_W    = $clog2(MAP_H);
  localparam logic [X_W-1:0] LAST_X = X_W'(MAP_W - TILE_W);
  localparam logic [Y_W-1:0] LAST_Y = Y_W'(MAP_H - TILE_H);

  logic [WORD_W-1:0] workWord;
  logic [X_W-1:0]    baseX, tileX;
  logic [Y_W-1:0]    baseY, tileY;
  logic              workLast;

  // first tree: spike to emit now
  logic              foundA;
  logic [IDX_W-1:0]  idxA;
  spkLzc #(.W(WORD_W)) uTreeCur (.vec(workWord), .found(foundA), .idx(idxA));

  // second tree: is there another spike once this one is gone
  logic [WORD_W-1:0] restWord;
  logic              foundB;
  logic [IDX_W-1:0]  idxB;
  assign restWord = workWord & ~(WORD_W'(1) << idxA);
  spkLzc #(.W(WORD_W)) uTreeNext (.vec(restWord), .found(foundB), .idx(idxB));

  // bit position to in-tile offset, filled at elaboration
  logic [X_W-1:0] lutDx [WORD_W];
  logic [Y_W-1:0] lutDy [WORD_W];
  genvar b;
  generate
    for (b = 0; b < WORD_W; b++) begin : gLut
      assign lutDx[b] = X_W'(b % TILE_W);
      assign lutDy[b] = Y_W'(b / TILE_W);
    end
  endgenerate

  assign outX = baseX + lutDx[idxA];
  assign outY = baseY + lutDy[idxA];

  logic tileLast;
  assign tileLast = (tileX == LAST_X) && (tileY == LAST_Y);

  always_comb begin
    status.inZero     = (inWord == '0);
    status.inTileLast = tileLast;
    status.oneLeft    = foundA && !foundB;
    status.workLast   = workLast;
    status.hasBit     = foundA;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      workWord <= '0;
      baseX    <= '0;
      baseY    <= '0;
      workLast <= 1'b0;
    end else if (strobe.load) begin
      workWord <= inWord;
      baseX    <= tileX;
      baseY    <= tileY;
      workLast <= tileLast;
    end else if (strobe.clearBit) begin
      workWord <= restWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tileX <= '0;
      tileY <= '0;
    end else if (strobe.advance) begin
      if (tileX == LAST_X) begin
        tileX <= '0;
        tileY <= (tileY == LAST_Y) ? '0 : tileY + Y_W'(TILE_H);
      end else begin
        tileX <= tileX + X_W'(TILE_W);
      end
    end
  end

  AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearBit && !strobe.load |=>
      $countones(workWord) + 1 == $past($countones(workWord))); // R3

  AST_TILE_IN_MAP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance && tileLast |=> tileX == '0 && tileY == '0); // R9

endmodule

// File: rtl/spkCtrl.sv
module spkCtrl
  import spkPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      outReady,
  input  spkStatusT status,
  output spkStrobeT strobe,
  output logic      inReady,
  output logic      outValid,
  output logic      outSpike,
  output logic      outEom
);
  logic busySpike, busyMarker;
  logic outFire, retire, inFire;

  always_comb begin
    outValid = busySpike | busyMarker;
    outFire  = outValid & outReady;
    retire   = outFire & (busyMarker | status.oneLeft);
    inReady  = !outValid | retire;
    inFire   = inValid & inReady;

    strobe.load     = inFire & !status.inZero;
    strobe.clearBit = outFire & busySpike;
    strobe.advance  = inFire;

    outSpike = busySpike;
    outEom   = busyMarker | (busySpike & status.workLast & status.oneLeft);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busySpike  <= 1'b0;
      busyMarker <= 1'b0;
    end else begin
      if (retire) begin
        busySpike  <= 1'b0;
        busyMarker <= 1'b0;
      end
      if (inFire) begin
        busySpike  <= !status.inZero;
        busyMarker <= status.inZero & status.inTileLast;
      end
    end
  end

  AST_SPIKE_HAS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    busySpike |-> status.hasBit); // R3

  AST_ONE_HOLDER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busySpike, busyMarker})); // R8

endmodule

// File: rtl/spikeStreamer.sv
module spikeStreamer
  import spkPkg::*;
#(
  parameter int TILE_W = 4,
  parameter int TILE_H = 4,
  parameter int MAP_W  = 32,
  parameter int MAP_H  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  output logic                         inReady,
  input  logic [TILE_W*TILE_H-1:0]     inWord,
  output logic                         outValid,
  input  logic                         outReady,
  output logic                         outSpike,
  output logic                         outEom,
  output logic [$clog2(MAP_W)-1:0]     outX,
  output logic [$clog2(MAP_H)-1:0]     outY
);
  spkStrobeT strobe;
  spkStatusT status;

  spkCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .status(status), .strobe(strobe), .inReady(inReady),
    .outValid(outValid), .outSpike(outSpike), .outEom(outEom)
  );

  spkDatapath #(.TILE_W(TILE_W), .TILE_H(TILE_H), .MAP_W(MAP_W), .MAP_H(MAP_H)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inWord(inWord),
    .status(status), .outX(outX), .outY(outY)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outSpike) && $stable(outEom)
      && (!outSpike || ($stable(outX) && $stable(outY)))); // R6

  AST_STALL_NO_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady); // R6

  AST_MARKER_IS_EOM: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outSpike |-> outEom); // R8

  AST_COORD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outSpike |-> 32'(outX) < MAP_W && 32'(outY) < MAP_H); // R2

endmodule

// File: tb/sim_spikeStreamer.sv
module sim_spikeStreamer;
  localparam int TW = 4, TH = 4, MW = 32, MH = 16;
  localparam int WW = TW * TH;
  localparam int TX = MW / TW, TY = MH / TH;
  localparam int PER_MAP = TX * TY;
  localparam int NMAP = 6;
  localparam int TOTAL = NMAP * PER_MAP;

  logic clk = 0, rstN = 0;
  logic inValid = 0, inReady, outValid, outReady = 0, outSpike, outEom;
  logic [WW-1:0] inWord = '0;
  logic [$clog2(MW)-1:0] outX;
  logic [$clog2(MH)-1:0] outY;

  always #4 clk = ~clk;

  spikeStreamer #(.TILE_W(TW), .TILE_H(TH), .MAP_W(MW), .MAP_H(MH)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inWord(inWord),
    .outValid(outValid), .outReady(outReady), .outSpike(outSpike), .outEom(outEom),
    .outX(outX), .outY(outY)
  );

  typedef struct { bit spk; int x; int y; bit eom; } beatT;
  beatT expQ[$];
  logic [WW-1:0] words [TOTAL];
  int modelTile = 0;
  int nChecks = 0, nFail = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void pushWord(logic [WW-1:0] w);
    int bx = (modelTile % TX) * TW;
    int by = (modelTile / TX) * TH;
    bit last = (modelTile == PER_MAP - 1);
    int n = $countones(w);
    int k = 0;
    for (int b = 0; b < WW; b++) begin
      if (w[b]) begin
        k++;
        expQ.push_back('{1'b1, bx + b % TW, by + b / TW, last && k == n});
      end
    end
    if (n == 0 && last) expQ.push_back('{1'b0, 0, 0, 1'b1});
    modelTile = last ? 0 : modelTile + 1;
  endfunction

  initial begin
    int wi = 0, cyc = 0;
    bit accepted = 0, prevStall = 0, fireOut, fireIn;
    bit pSpk, pEom; int px, py;
    bit expValid, expReady;
    for (int i = 0; i < TOTAL; i++) begin
      int m = i / PER_MAP;
      logic [WW-1:0] r = WW'($urandom);
      case (m)
        0: words[i] = r;
        1: words[i] = r & WW'($urandom) & WW'($urandom);
        2: words[i] = '0;
        3: words[i] = ($urandom % 2) ? r & WW'($urandom) : '0;
        4: words[i] = WW'(1) << ($urandom % WW);
        default: words[i] = '1;
      endcase
      if (i % PER_MAP == PER_MAP - 1) begin
        if (m == 0) words[i] = words[i] | WW'(1) | (WW'(1) << (WW - 1));
        if (m == 3) words[i] = '0;  // map ends on an empty tile
      end
    end

    repeat (3) @(negedge clk);
    chk(outValid == 0, "R1 outValid at reset", int'(outValid), 0);
    chk(inReady == 1, "R1 inReady at reset", int'(inReady), 1);
    rstN = 1;

    while (cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (accepted) begin inValid = 0; wi++; accepted = 0; end
      if (!inValid && wi < TOTAL && ($urandom % 4 != 0)) begin
        inValid = 1;
        inWord  = words[wi];
      end
      outReady = ((wi / PER_MAP) % 2 == 1) ? ($urandom % 3 != 0) : 1'b1;
      #1;
      expValid = expQ.size() > 0;
      expReady = (expQ.size() == 0) || (outReady && expQ.size() == 1);
      chk(inReady == expReady, "R4 R5 R6 inReady", int'(inReady), int'(expReady));
      chk(outValid == expValid, "R3 outValid", int'(outValid), int'(expValid));
      if (outValid && expValid) begin
        chk(outSpike == expQ[0].spk, "R3 R8 outSpike", int'(outSpike), int'(expQ[0].spk));
        chk(outEom == expQ[0].eom, "R7 R8 outEom", int'(outEom), int'(expQ[0].eom));
        if (expQ[0].spk) begin
          chk(int'(outX) == expQ[0].x, "R2 R9 outX", int'(outX), expQ[0].x);
          chk(int'(outY) == expQ[0].y, "R2 R9 outY", int'(outY), expQ[0].y);
        end
      end
      if (prevStall) begin
        chk(outValid && outSpike == pSpk && outEom == pEom, "R6 held beat",
            int'(outSpike), int'(pSpk));
        if (pSpk) chk(int'(outX) == px && int'(outY) == py, "R6 held coords",
                      int'(outX) * 100 + int'(outY), px * 100 + py);
      end
      fireOut = outValid && outReady;
      fireIn  = inValid && inReady;
      prevStall = outValid && !outReady;
      pSpk = outSpike; pEom = outEom; px = int'(outX); py = int'(outY);
      @(posedge clk);
      if (fireOut && expQ.size() > 0) void'(expQ.pop_front());
      if (fireIn) begin pushWord(inWord); accepted = 1; end
      if (wi >= TOTAL - 1 && accepted && expQ.size() == 0 && wi + 1 == TOTAL) begin
        @(negedge clk);
        inValid = 0;
        wi++;
        accepted = 0;
        break;
      end
      if (wi >= TOTAL && !inValid && expQ.size() == 0) break;
    end
    if (cyc >= 20000) chk(1'b0, "watchdog expired", cyc, 20000);
    repeat (2) @(negedge clk);
    chk(outValid == 0, "R3 R8 idle after last map", int'(outValid), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule